// File: doc/BRIEF.md
# Time-Slot Data Link Extractor

This block recovers a low-rate serial data link carried inside a received T1 or E1 bit stream. It counts bit positions from a frame-start marker, picks out bits of one configured time slot (or, in T1, the framing bit) in every frame, in odd frames only or in even frames only, and packs the picked bits into 8-bit or 6-bit words. The words go into a 64-entry receive FIFO that a processor empties with a pop strobe.

A three-state controller governs capture. `ST_OFF` is held while the enable is low. Raising the enable moves it to `ST_HUNT`, where it waits for the first frame-start. That frame-start moves it to `ST_RUN`, where it extracts bits until the enable drops. Dropping the enable returns it to `ST_OFF` from either of the other two states. A frame-start bit seen in `ST_HUNT` belongs to frame 1 and may itself be captured. Frame parity starts odd at that first frame and toggles at every later frame-start.

Top module: `dlx_extract`

## Requirements
- R1: While `cfg_enable` is low, no bit is captured and nothing is written to the FIFO. After enable rises, capture starts at the next frame-start.
- R2: `cfg_frame_sel` encodes 0 = all frames, 1 = odd frames only, 2 = even frames only, 3 = all frames. The first frame that starts after enable is frame 1, which is odd.
- R3: In E1 mode (`mode_e1`=1), slot s (0..31) is made of bit positions 8s to 8s+7. Position 0 is the bit that carries `frame_start`.
- R4: In T1 mode, slot value 0 selects the framing bit at position 0, and the bit mask is ignored for it. Slot n in 1..24 is made of positions 8n-7 to 8n. Slot values 25..31 capture nothing.
- R5: Mask bit 7 enables the first line bit of the slot. Mask bit 0 enables the last.
- R6: In 8-bit packing (`cfg_pack6`=0), each FIFO word holds 8 captured bits, and the earliest of them is in bit 7.
- R7: In 6-bit packing (`cfg_pack6`=1), each FIFO word holds 6 captured bits, with the earliest in bit 5. Bits 7:6 read as zero.
- R8: The FIFO holds 64 words. `fifo_count` gives the number stored, and `fifo_empty` is high exactly when that number is zero.
- R9: A word completed while the FIFO is full is discarded, and `overflow` is set. `overflow` stays set until a cycle with `ovf_clear` high and no new overflow.
- R10: A `pop` while the FIFO is not empty presents the oldest word on `pop_data`, with `pop_valid` high, on the following cycle. A `pop` on an empty FIFO does nothing.
- R11: Lowering the enable discards a partly assembled word. Words already stored in the FIFO are kept.
- R12: Cycles with `rx_valid` low neither advance the bit position nor capture anything.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_bit | input | 1 | Received line bit |
| rx_valid | input | 1 | Qualifies rx_bit and frame_start |
| frame_start | input | 1 | Marks the first bit of a frame |
| mode_e1 | input | 1 | 1 = E1 (256-bit frame), 0 = T1 (193-bit frame) |
| cfg_enable | input | 1 | Extraction enable |
| cfg_frame_sel | input | 2 | Frame selection: all, odd or even |
| cfg_slot | input | 5 | Time slot number |
| cfg_bit_mask | input | 8 | Bits of the slot to capture |
| cfg_pack6 | input | 1 | 1 = 6-bit words, 0 = 8-bit words |
| ovf_clear | input | 1 | Write-one-to-clear for overflow |
| pop | input | 1 | Read strobe for the FIFO |
| pop_data | output | 8 | Word returned by a pop |
| pop_valid | output | 1 | pop_data holds a popped word this cycle |
| fifo_count | output | 7 | Number of stored words |
| fifo_empty | output | 1 | FIFO holds no word |
| overflow | output | 1 | Sticky word-dropped flag |

## Verification
The assertions check on every cycle that no word is produced while disabled, that the fill level stays within 64 and moves by at most one per cycle, that the empty flag agrees with the level, that `overflow` only rises at a full FIFO and stays set without a clear, and that `pop_valid` follows exactly the pops made on a non-empty FIFO. Only the bench scenarios can show which line bits land in which word. That covers slot and framing-bit positions in both modes, mask ordering, odd/even selection counted from the first frame after enable, 6-bit versus 8-bit packing, that words come out oldest first, and that a disable discards exactly the partial word.

// File: rtl/dlx_pkg.sv
package dlx_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_HUNT = 2'd1,
        ST_RUN  = 2'd2
    } trk_state_e;

    localparam logic [1:0] FSEL_ALL  = 2'd0;
    localparam logic [1:0] FSEL_ODD  = 2'd1;
    localparam logic [1:0] FSEL_EVEN = 2'd2;

endpackage

// File: rtl/dlx_slot_tracker.sv
module dlx_slot_tracker
    import dlx_pkg::*;
#(
    parameter int SLOT_W   = 5,
    parameter int T1_SLOTS = 24,
    parameter int POS_W    = SLOT_W + 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              mode_e1,
    input  logic              rx_valid,
    input  logic              rx_bit,
    input  logic              frame_start,
    input  logic [1:0]        frame_sel,
    input  logic [SLOT_W-1:0] slot,
    input  logic [7:0]        mask,
    output logic              cap_valid,
    output logic              cap_bit
);

    localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};

    trk_state_e        state_q, state_d;
    logic [POS_W-1:0]  pos_q, cur_pos;
    logic              odd_q, cur_odd;
    logic              is_fs, live, parity_ok;
    logic [POS_W-1:0]  t1_base, t1_off;
    logic              f_hit, t1_hit, e1_hit, bit_on;
    logic [2:0]        idx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:  if (enable) state_d = ST_HUNT;
            ST_HUNT: if (!enable) state_d = ST_OFF;
                     else if (is_fs) state_d = ST_RUN;
            ST_RUN:  if (!enable) state_d = ST_OFF;
            default: state_d = ST_OFF;
        endcase
    end

    assign is_fs = rx_valid && frame_start;

    // outputs
    always_comb begin
        live    = 1'b0;
        cur_odd = odd_q;
        unique case (state_q)
            ST_OFF:  begin
                live    = 1'b0;
                cur_odd = 1'b0;
            end
            ST_HUNT: begin
                live    = enable && is_fs;
                cur_odd = 1'b1;
            end
            ST_RUN:  begin
                live    = enable;
                cur_odd = is_fs ? ~odd_q : odd_q;
            end
            default: begin
                live    = 1'b0;
                cur_odd = 1'b0;
            end
        endcase

        unique case (frame_sel)
            FSEL_ODD:  parity_ok = cur_odd;
            FSEL_EVEN: parity_ok = ~cur_odd;
            default:   parity_ok = 1'b1;
        endcase

        cur_pos = is_fs ? '0 : pos_q;

        t1_base = POS_W'({slot, 3'b000}) - POS_W'(7);
        t1_off  = cur_pos - t1_base;
        f_hit   = !mode_e1 && (slot == '0) && (cur_pos == '0);
        t1_hit  = !mode_e1 && (slot != '0) && (slot <= SLOT_W'(T1_SLOTS))
                  && (cur_pos >= t1_base) && (t1_off < POS_W'(8));
        e1_hit  = mode_e1 && (cur_pos[POS_W-1:SLOT_W+3] == '0)
                  && (cur_pos[SLOT_W+2:3] == slot);
        idx     = mode_e1 ? cur_pos[2:0] : t1_off[2:0];
        bit_on  = mask[3'd7 - idx];

        cap_valid = live && rx_valid && parity_ok
                    && (f_hit || ((t1_hit || e1_hit) && bit_on));
        cap_bit   = rx_bit;
    end

    // bit position and frame parity
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
            odd_q <= 1'b0;
        end else if (state_q == ST_OFF || !enable) begin
            pos_q <= '0;
            odd_q <= 1'b0;
        end else if (rx_valid) begin
            pos_q <= (cur_pos == POS_MAX) ? POS_MAX : cur_pos + 1'b1;
            if (is_fs) odd_q <= cur_odd;
        end
    end

endmodule

// File: rtl/dlx_packer.sv
module dlx_packer #(
    parameter int WORD_W  = 8,
    parameter int SHORT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              pack6,
    input  logic              cap_valid,
    input  logic              cap_bit,
    output logic              push_valid,
    output logic [WORD_W-1:0] push_data
);

    localparam int CNT_W = $clog2(WORD_W) + 1;
    localparam logic [WORD_W-1:0] SHORT_MASK = WORD_W'((1 << SHORT_W) - 1);

    logic [WORD_W-1:0] sh_q, sh_next;
    logic [CNT_W-1:0]  cnt_q, cnt_next, target;

    assign sh_next  = {sh_q[WORD_W-2:0], cap_bit};
    assign cnt_next = cnt_q + 1'b1;
    assign target   = pack6 ? CNT_W'(SHORT_W) : CNT_W'(WORD_W);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q       <= '0;
            cnt_q      <= '0;
            push_valid <= 1'b0;
            push_data  <= '0;
        end else if (flush) begin
            cnt_q      <= '0;
            push_valid <= 1'b0;
        end else begin
            push_valid <= 1'b0;
            if (cap_valid) begin
                sh_q <= sh_next;
                if (cnt_next >= target) begin
                    cnt_q      <= '0;
                    push_valid <= 1'b1;
                    push_data  <= pack6 ? (sh_next & SHORT_MASK) : sh_next;
                end else begin
                    cnt_q <= cnt_next;
                end
            end
        end
    end

endmodule

// File: rtl/dlx_rx_fifo.sv
module dlx_rx_fifo #(
    parameter int DEPTH = 64,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    input  logic          ovf_clear,
    output logic [W-1:0]  pop_data,
    output logic          pop_valid,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          overflow
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          full, do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr    <= '0;
            rd_ptr    <= '0;
            count     <= '0;
            pop_valid <= 1'b0;
            pop_data  <= '0;
            overflow  <= 1'b0;
        end else begin
            pop_valid <= do_pop;
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop) begin
                pop_data <= mem[rd_ptr];
                rd_ptr   <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
            if (push && full)   overflow <= 1'b1;
            else if (ovf_clear) overflow <= 1'b0;
        end
    end

endmodule

// File: rtl/dlx_extract.sv
module dlx_extract
    import dlx_pkg::*;
#(
    parameter int FIFO_DEPTH = 64,
    parameter int SLOT_W     = 5,
    parameter int T1_SLOTS   = 24,
    localparam int CNT_W     = $clog2(FIFO_DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_bit,
    input  logic              rx_valid,
    input  logic              frame_start,
    input  logic              mode_e1,
    input  logic              cfg_enable,
    input  logic [1:0]        cfg_frame_sel,
    input  logic [SLOT_W-1:0] cfg_slot,
    input  logic [7:0]        cfg_bit_mask,
    input  logic              cfg_pack6,
    input  logic              ovf_clear,
    input  logic              pop,
    output logic [7:0]        pop_data,
    output logic              pop_valid,
    output logic [CNT_W-1:0]  fifo_count,
    output logic              fifo_empty,
    output logic              overflow
);

    logic       cap_valid, cap_bit;
    logic       push_valid;
    logic [7:0] push_data;

    dlx_slot_tracker #(
        .SLOT_W   (SLOT_W),
        .T1_SLOTS (T1_SLOTS)
    ) u_trk (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (cfg_enable),
        .mode_e1     (mode_e1),
        .rx_valid    (rx_valid),
        .rx_bit      (rx_bit),
        .frame_start (frame_start),
        .frame_sel   (cfg_frame_sel),
        .slot        (cfg_slot),
        .mask        (cfg_bit_mask),
        .cap_valid   (cap_valid),
        .cap_bit     (cap_bit)
    );

    dlx_packer #(
        .WORD_W  (8),
        .SHORT_W (6)
    ) u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (!cfg_enable),
        .pack6      (cfg_pack6),
        .cap_valid  (cap_valid),
        .cap_bit    (cap_bit),
        .push_valid (push_valid),
        .push_data  (push_data)
    );

    dlx_rx_fifo #(
        .DEPTH (FIFO_DEPTH),
        .W     (8)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push_valid),
        .push_data (push_data),
        .pop       (pop),
        .ovf_clear (ovf_clear),
        .pop_data  (pop_data),
        .pop_valid (pop_valid),
        .count     (fifo_count),
        .empty     (fifo_empty),
        .overflow  (overflow)
    );

endmodule

// File: rtl/dlx_checker.sv
module dlx_checker #(
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_enable,
    input logic          push_valid,
    input logic          pop,
    input logic          ovf_clear,
    input logic          pop_valid,
    input logic [CW-1:0] fifo_count,
    input logic          fifo_empty,
    input logic          overflow
);

    a_r1_idle_no_push: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> !push_valid);

    a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CW'(DEPTH));

    a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (fifo_count == $past(fifo_count))
              || (fifo_count == $past(fifo_count) + 1'b1)
              || (fifo_count + 1'b1 == $past(fifo_count)));

    a_r8_empty_flag: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_empty == (fifo_count == '0));

    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow && !ovf_clear |=> overflow);

    a_r9_ovf_rise_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> $past(fifo_count) == CW'(DEPTH));

    a_r10_pop_valid: assert property (@(posedge clk) disable iff (!rst_n)
        pop && !fifo_empty |=> pop_valid);

    a_r10_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !(pop && !fifo_empty) |=> !pop_valid);

endmodule

bind dlx_extract dlx_checker #(.DEPTH(FIFO_DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_enable (cfg_enable),
    .push_valid (push_valid),
    .pop        (pop),
    .ovf_clear  (ovf_clear),
    .pop_valid  (pop_valid),
    .fifo_count (fifo_count),
    .fifo_empty (fifo_empty),
    .overflow   (overflow)
);

// File: tb/sim_dlx_extract.sv
module sim_dlx_extract;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_bit = 1'b0, rx_valid = 1'b0, frame_start = 1'b0, mode_e1 = 1'b1;
    logic       cfg_enable = 1'b0, cfg_pack6 = 1'b0, ovf_clear = 1'b0, pop = 1'b0;
    logic [1:0] cfg_frame_sel = 2'd0;
    logic [4:0] cfg_slot = 5'd0;
    logic [7:0] cfg_bit_mask = 8'h00;
    logic [7:0] pop_data;
    logic       pop_valid, fifo_empty, overflow;
    logic [6:0] fifo_count;

    int         n_checks = 0;
    int         n_errors = 0;
    int         bench_frame = 0;
    logic [7:0] part = 8'h00;
    int         part_n = 0;
    logic [7:0] exp_q[$];
    logic       exp_ovf = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    bit         done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dlx_extract u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx_bit        (rx_bit),
        .rx_valid      (rx_valid),
        .frame_start   (frame_start),
        .mode_e1       (mode_e1),
        .cfg_enable    (cfg_enable),
        .cfg_frame_sel (cfg_frame_sel),
        .cfg_slot      (cfg_slot),
        .cfg_bit_mask  (cfg_bit_mask),
        .cfg_pack6     (cfg_pack6),
        .ovf_clear     (ovf_clear),
        .pop           (pop),
        .pop_data      (pop_data),
        .pop_valid     (pop_valid),
        .fifo_count    (fifo_count),
        .fifo_empty    (fifo_empty),
        .overflow      (overflow)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // expected selection, from the requirements
    function automatic bit model_sel(input int pos);
        bit odd = (bench_frame % 2) == 1;
        bit pok;
        int lo;
        case (cfg_frame_sel)
            2'd1:    pok = odd;
            2'd2:    pok = !odd;
            default: pok = 1'b1;
        endcase
        if (!pok) return 1'b0;
        if (!mode_e1) begin
            if (cfg_slot == 0) return pos == 0;
            if (cfg_slot > 24) return 1'b0;
            lo = 8 * int'(cfg_slot) - 7;
            if (pos >= lo && pos < lo + 8) return cfg_bit_mask[7 - (pos - lo)];
            return 1'b0;
        end
        if (pos / 8 == int'(cfg_slot)) return cfg_bit_mask[7 - (pos % 8)];
        return 1'b0;
    endfunction

    task automatic model_take(input logic b);
        part = {part[6:0], b};
        part_n++;
        if (part_n == (cfg_pack6 ? 6 : 8)) begin
            if (exp_q.size() < 64) exp_q.push_back(cfg_pack6 ? {2'b00, part[5:0]} : part);
            else exp_ovf = 1'b1;
            part_n = 0;
        end
    endtask

    // R12: idle cycles with rx_valid low are mixed into every frame
    task automatic send_frames(input int n);
        for (int f = 0; f < n; f++) begin
            int len = mode_e1 ? 256 : 193;
            bench_frame++;
            for (int pos = 0; pos < len; pos++) begin
                if (pos % 7 == 3) begin
                    @(negedge clk);
                    rx_valid = 1'b0; frame_start = 1'b0; rx_bit = ~lfsr[0];
                end
                @(negedge clk);
                rx_valid    = 1'b1;
                frame_start = (pos == 0);
                rx_bit      = lfsr[0];
                if (cfg_enable && model_sel(pos)) model_take(lfsr[0]);
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            end
        end
        @(negedge clk);
        rx_valid = 1'b0; frame_start = 1'b0;
    endtask

    task automatic configure(input logic e1, input logic [1:0] fsel, input logic [4:0] slot,
                             input logic [7:0] mask, input logic p6);
        @(negedge clk);
        cfg_enable = 1'b0;
        part_n = 0;
        repeat (2) @(negedge clk);
        mode_e1 = e1; cfg_frame_sel = fsel; cfg_slot = slot;
        cfg_bit_mask = mask; cfg_pack6 = p6;
        cfg_enable = 1'b1;
        bench_frame = 0;
        @(negedge clk);
    endtask

    task automatic drain_compare(input string req);
        int n;
        repeat (4) @(negedge clk);
        n = exp_q.size();
        check({req, " count"}, 32'(fifo_count), 32'(n));
        for (int i = 0; i < n; i++) begin
            logic [7:0] e = exp_q.pop_front();
            pop = 1'b1;
            @(negedge clk);
            pop = 1'b0;
            check({req, " R10 pop_valid"}, 32'(pop_valid), 32'd1);
            check({req, " data"}, 32'(pop_data), 32'(e));
        end
        @(negedge clk);
        check({req, " R8 empty"}, 32'(fifo_empty), 32'd1);
        exp_q.delete();
    endtask

    task automatic t_reset();
        check("R8 reset count", 32'(fifo_count), 32'd0);
        check("R8 reset empty", 32'(fifo_empty), 32'd1);
        check("R9 reset overflow", 32'(overflow), 32'd0);
        check("R10 reset pop_valid", 32'(pop_valid), 32'd0);
    endtask

    task automatic t_disabled();
        cfg_enable = 1'b0; mode_e1 = 1'b1; cfg_slot = 5'd2; cfg_bit_mask = 8'hFF;
        send_frames(3);
        repeat (4) @(negedge clk);
        check("R1 disabled no words", 32'(fifo_count), 32'd0);
    endtask

    task automatic t_pop_empty();
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
        check("R10 pop on empty", 32'(pop_valid), 32'd0);
        check("R10 count after empty pop", 32'(fifo_count), 32'd0);
    endtask

    task automatic t_e1_full_slot();
        configure(1'b1, 2'd0, 5'd5, 8'hFF, 1'b0);
        send_frames(2);
        drain_compare("R3 R6 R12 e1 slot5");
    endtask

    task automatic t_e1_mask_odd();
        configure(1'b1, 2'd1, 5'd9, 8'h81, 1'b0);
        send_frames(8);
        drain_compare("R2 R5 e1 odd mask81");
    endtask

    task automatic t_e1_last_even6();
        configure(1'b1, 2'd2, 5'd31, 8'hFF, 1'b1);
        send_frames(4);
        drain_compare("R2 R7 e1 slot31 even pack6");
    endtask

    task automatic t_t1_fbit();
        configure(1'b0, 2'd1, 5'd0, 8'h00, 1'b1);
        send_frames(24);
        drain_compare("R4 R7 t1 fbit odd");
        configure(1'b0, 2'd2, 5'd0, 8'h5A, 1'b1);
        send_frames(24);
        drain_compare("R4 R2 t1 fbit even");
    endtask

    task automatic t_t1_edges();
        configure(1'b0, 2'd3, 5'd24, 8'h0F, 1'b0);
        send_frames(2);
        drain_compare("R4 R5 t1 slot24");
        configure(1'b0, 2'd0, 5'd28, 8'hFF, 1'b0);
        send_frames(2);
        drain_compare("R4 t1 slot28 none");
    endtask

    task automatic t_flush();
        configure(1'b1, 2'd0, 5'd3, 8'hF0, 1'b0);
        send_frames(3);
        configure(1'b1, 2'd0, 5'd3, 8'hF0, 1'b0);
        send_frames(2);
        drain_compare("R11 flush keeps stored");
    endtask

    task automatic t_overflow();
        exp_ovf = 1'b0;
        configure(1'b1, 2'd0, 5'd1, 8'hFF, 1'b0);
        send_frames(66);
        repeat (4) @(negedge clk);
        check("R9 overflow set", 32'(overflow), 32'(exp_ovf));
        check("R8 full count", 32'(fifo_count), 32'd64);
        @(negedge clk);
        cfg_enable = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 overflow sticky", 32'(overflow), 32'd1);
        ovf_clear = 1'b1;
        @(negedge clk);
        ovf_clear = 1'b0;
        check("R9 overflow cleared", 32'(overflow), 32'd0);
        drain_compare("R9 R8 kept oldest");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_pop_empty();
        t_e1_full_slot();
        t_e1_mask_odd();
        t_e1_last_even6();
        t_t1_fbit();
        t_t1_edges();
        t_flush();
        t_overflow();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule